// File: doc/BRIEF.md
# Synchronous Burst Data SRAM

This block models the data storage of a secondary cache: a synchronous SRAM with a built-in burst address counter. On each rising clock edge it samples its controls, address and 9-bit write data. A low address strobe either deselects the device or starts a burst at the external address. A high address strobe either steps the internal address or holds it in place. Every selected cycle is a read or a write, chosen by the write enable in that cycle.

Holding the address (suspending the burst) accesses the same location again, and this is how a controller adds wait states. Read data is registered and appears one cycle after the edge. An asynchronous output enable gates the output. The high-impedance state is shown by a valid flag beside the data bus, and the bus reads zero whenever the flag is low.

Top module: `burst_sram`

## Requirements
- R1: With `strobe_n` low and `chip_idle` high at a rising edge, the device is deselected: no location is written, `rvalid` is low after the edge, and later step or hold cycles access nothing until a new burst is started.
- R2: With `strobe_n` low and `chip_idle` low at a rising edge, `addr` is loaded as the burst address and that location is accessed: written with `wdata` if `wr_n` is low, read if `wr_n` is high.
- R3: With `strobe_n` high and `adv_n` low on a selected device, the low 2 address bits increment modulo 4 (for example 2, 3, 0, 1), the upper bits stay fixed, the new address is accessed, and `chip_idle` has no effect.
- R4: With `strobe_n` high and `adv_n` high on a selected device, the burst address is held and the same location is read or written again.
- R5: Read data for an access at a rising edge is presented on `rdata` after that edge, which is one cycle of latency.
- R6: `rvalid` is high only after a read cycle while `oe_n` is low. It follows `oe_n` without a clock edge, and `rdata` is zero whenever `rvalid` is low.
- R7: After a write cycle, `rvalid` is low whatever the level of `oe_n`.
- R8: After reset the device is deselected and `rvalid` is low. Step or hold cycles before the first burst start neither write nor drive the output.
- R9: All 9 data bits, including bit 8, are stored and returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_idle | input | 1 | Standby; deselects the device when high during a strobe |
| strobe_n | input | 1 | Address strobe, active low |
| adv_n | input | 1 | Count enable, active low; steps the burst address |
| wr_n | input | 1 | Write enable, active low |
| addr | input | AW | External address |
| wdata | input | DW | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | DW | Read data, zero when not driven |
| rvalid | output | 1 | High while `rdata` is driven |

## Verification
The assertions assume that every control input has a known level at each rising edge and does not change near that edge. The stimulus changes all synchronous inputs on the falling edge. It moves `oe_n` only between edges, which lets the bench observe the asynchronous gating without a clock. The memory has no reset, so every location the bench reads is written earlier in the same run.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int AW = 8,
  parameter int DW = 9,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chip_idle,
  input  logic          strobe_n,
  input  logic          adv_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          oe_n,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] cur_addr;
  logic          sel;
  logic          rd_q;
  logic [DW-1:0] q;

  wire start = !strobe_n && !chip_idle;
  wire desel = !strobe_n && chip_idle;
  wire step  = strobe_n && !adv_n && sel;
  wire stall = strobe_n && adv_n && sel;
  wire access = start || step || stall;

  wire [BW-1:0] low_inc = cur_addr[BW-1:0] + 1'b1;
  wire [AW-1:0] use_addr = start ? addr :
                           step  ? {cur_addr[AW-1:BW], low_inc} : cur_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      sel      <= 1'b0;
      rd_q     <= 1'b0;
      q        <= '0;
    end else begin
      if (start || step) cur_addr <= use_addr;
      if (start) sel <= 1'b1;
      else if (desel) sel <= 1'b0;
      rd_q <= access && wr_n;
      if (access && wr_n) q <= mem[use_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (access && !wr_n) mem[use_addr] <= wdata;
  end

  assign rvalid = rd_q && !oe_n;
  assign rdata  = rvalid ? q : '0;

  AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && chip_idle) |=> !rvalid); // R1
  AST_BEGIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && !chip_idle) |=> (cur_addr == $past(addr))); // R2
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_n && !adv_n && sel) |=> ((cur_addr[BW-1:0] == $past(cur_addr[BW-1:0]) + 1'b1) && $stable(cur_addr[AW-1:BW]))); // R3
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_n && adv_n) |=> $stable(cur_addr)); // R4
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n) |=> !rvalid); // R7
endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_idle = 1'b1;
  logic       strobe_n = 1'b0;
  logic       adv_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] addr = '0;
  logic [8:0] wdata = '0;
  logic       oe_n = 1'b0;
  logic [8:0] rdata;
  logic       rvalid;
  int checks = 0;
  int errors = 0;

  localparam logic [8:0] A0 = 9'h0A5, A1 = 9'h15A, A2 = 9'h033, A3 = 9'h1C7;

  always #2 clk = ~clk;

  burst_sram dut_i (.clk(clk), .rst_n(rst_n), .chip_idle(chip_idle), .strobe_n(strobe_n),
    .adv_n(adv_n), .wr_n(wr_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .rvalid(rvalid));

  task automatic cyc(input logic s_n, input logic idle, input logic a_n, input logic w_n,
                     input logic [7:0] ad, input logic [8:0] wd);
    @(negedge clk);
    strobe_n = s_n; chip_idle = idle; adv_n = a_n; wr_n = w_n; addr = ad; wdata = wd;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic ev, input logic [8:0] ed);
    checks++;
    if (rvalid !== ev || rdata !== ed) begin
      errors++;
      $display("FAIL %s: actual valid=%0b data=%h expected valid=%0b data=%h", req, rvalid, rdata, ev, ed);
    end
  endtask

  task automatic t_reset;
    chk("R8 reset", 1'b0, 9'h000);
    cyc(1, 0, 0, 1, 8'h00, 9'h000); chk("R8 step before start", 1'b0, 9'h000);
    cyc(1, 0, 1, 0, 8'h00, 9'h1FF); chk("R8 hold write before start", 1'b0, 9'h000);
  endtask

  task automatic t_write_burst;
    cyc(0, 0, 1, 0, 8'h12, A0); chk("R7 begin write", 1'b0, 9'h000);
    cyc(1, 0, 0, 0, 8'h00, A1); chk("R7 step write", 1'b0, 9'h000);
    cyc(1, 1, 0, 0, 8'h00, A2);
    cyc(1, 0, 0, 0, 8'h00, A3);
    cyc(0, 1, 1, 1, 8'h00, 9'h000);
  endtask

  task automatic t_read_burst;
    cyc(0, 0, 1, 1, 8'h12, 9'h000); chk("R2 R5 begin read 0x12", 1'b1, A0);
    cyc(1, 1, 0, 1, 8'h00, 9'h000); chk("R3 step to 0x13", 1'b1, A1);
    cyc(1, 1, 0, 1, 8'hFF, 9'h000); chk("R3 wrap to 0x10", 1'b1, A2);
    cyc(1, 0, 0, 1, 8'h00, 9'h000); chk("R3 step to 0x11", 1'b1, A3);
    cyc(1, 0, 0, 1, 8'h00, 9'h000); chk("R3 wrap to 0x12", 1'b1, A0);
  endtask

  task automatic t_suspend;
    cyc(0, 0, 1, 1, 8'h10, 9'h000); chk("R2 begin read 0x10", 1'b1, A2);
    cyc(1, 0, 1, 1, 8'h00, 9'h000); chk("R4 hold rereads 0x10", 1'b1, A2);
    cyc(1, 0, 0, 1, 8'h00, 9'h000); chk("R4 step after hold", 1'b1, A3);
  endtask

  task automatic t_oe;
    cyc(0, 0, 1, 1, 8'h13, 9'h000); chk("R6 read with oe", 1'b1, A1);
    #0.5 oe_n = 1'b1; #0.5; chk("R6 oe high", 1'b0, 9'h000);
    oe_n = 1'b0; #0.5; chk("R6 oe low again", 1'b1, A1);
    cyc(1, 0, 1, 0, 8'h00, A1); chk("R7 hold write with oe low", 1'b0, 9'h000);
  endtask

  task automatic t_deselect;
    cyc(0, 1, 1, 0, 8'h12, 9'h1FF); chk("R1 deselect no drive", 1'b0, 9'h000);
    cyc(1, 0, 0, 0, 8'h00, 9'h1FF); chk("R1 step after deselect", 1'b0, 9'h000);
    cyc(0, 0, 1, 1, 8'h12, 9'h000); chk("R1 location unchanged", 1'b1, A0);
    cyc(0, 0, 1, 1, 8'h13, 9'h000); chk("R1 next location unchanged", 1'b1, A1);
  endtask

  task automatic t_width;
    cyc(0, 0, 1, 0, 8'h45, 9'h0F0);
    cyc(0, 0, 1, 0, 8'h44, 9'h111);
    cyc(1, 0, 1, 0, 8'h00, 9'h100);
    cyc(0, 0, 1, 1, 8'h44, 9'h000); chk("R4 R9 hold write overwrites", 1'b1, 9'h100);
    cyc(0, 0, 1, 1, 8'h45, 9'h000); chk("R4 neighbour untouched", 1'b1, 9'h0F0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    t_reset;
    t_write_burst;
    t_read_burst;
    t_suspend;
    t_oe;
    t_deselect;
    t_width;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule